// File: doc/BRIEF.md
# Power-Up Synthesizer Configuration Sequencer

This block takes over from a small microcontroller in a frequency-synthesizer subsystem. When reset is released it programs a synthesizer through a three-wire serial port made of a serial clock, a data line and a latch strobe. It sends four 24-bit configuration words in a fixed order: initialization, function, N divider, reference divider. Each word goes out as three byte passes, high byte first, with the most significant bit of each byte first. A latch pulse follows each word.

The serial timing comes from a prescaler of the system clock. Every bit uses three equal phases: data setup with the clock low, clock high, and data hold with the clock low. Each phase lasts `PHASE_CYC` system cycles. With a 100 MHz system clock and the default of four cycles, each phase is 40 ns. This meets the synthesizer's minima: 10 ns data setup and hold, 25 ns clock high and low, 10 ns from clock to strobe, and 20 ns of strobe width.

The block takes its words from the `cfg_words` bus and captures them when the sequence starts. After the fourth strobe it raises `done` and stays idle. A `start` pulse while idle captures the bus again and runs the whole sequence once more.

Top module: `synth_cfg_seq`

## Requirements
- R1: While `rst_n` is low, `ser_clk`, `ser_data`, `latch_en` and `done` are all low.
- R2: One run sends exactly four words, each followed by one `latch_en` pulse. Word 0 is `cfg_words[23:0]` (initialization) and goes first. Words 1, 2 and 3 follow, each taken from the next higher 24-bit slice of `cfg_words`.
- R3: Exactly 24 rising edges of `ser_clk` come before each `latch_en` pulse. The data sampled on those edges is the word from bit 23 down to bit 0, so the byte passes go high, middle, low.
- R4: `ser_data` is stable for at least `PHASE_CYC` cycles before each rising edge of `ser_clk`. `ser_clk` is high for exactly `PHASE_CYC` cycles. `ser_data` does not change while `ser_clk` is high, nor within `PHASE_CYC` cycles after `ser_clk` falls.
- R5: `latch_en` is high for exactly `PHASE_CYC` cycles. It rises at least `PHASE_CYC` cycles after the last fall of `ser_clk`, and `ser_clk` stays low while `latch_en` is high.
- R6: `done` rises in the same cycle in which the fourth `latch_en` pulse ends.
- R7: While `done` is high and `start` is low, `done` stays high and `ser_clk`, `ser_data` and `latch_en` stay low.
- R8: If `start` is high at a clock edge while `done` is high, `done` is low from that edge onward. `cfg_words` is captured at that edge and the full four-word sequence repeats.
- R9: `start` has no effect while a run is in progress. Changes on `cfg_words` after capture do not alter the words that are sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Re-run request, honoured only while idle |
| cfg_words | input | NUM_WORDS*BYTE_W*BYTES_PER_WORD | Configuration words, word 0 in the lowest slice |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, MSB first |
| latch_en | output | 1 | Latch strobe, one pulse after each word |
| done | output | 1 | High once all words are latched |

## Verification
The bench builds the block with `PHASE_CYC` set to 3. This is not a power of two, so the phase counter has to wrap at an arbitrary count and cannot rely on a natural roll-over. It also keeps each run short enough to include several reruns, a restart from an abort in mid-word, and an idle stretch. The byte and word parameters stay at their defaults, so the three-byte boundary inside each word and the step from the last word to idle are crossed on every run.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  typedef enum logic [2:0] {
    ST_LOAD  = 3'd0,
    ST_SETUP = 3'd1,
    ST_HIGH  = 3'd2,
    ST_HOLD  = 3'd3,
    ST_GAP   = 3'd4,
    ST_LATCH = 3'd5,
    ST_DONE  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/cfg_phase_timer.sv
module cfg_phase_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);

  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = (cnt_q == CNT_LAST);

  always_comb begin
    if (clear || tick) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/cfg_word_shifter.sv
module cfg_word_shifter #(
  parameter int BYTE_W         = 8,
  parameter int BYTES_PER_WORD = 3,
  parameter int NUM_WORDS      = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NUM_WORDS*BYTE_W*BYTES_PER_WORD-1:0] words_in,
  input  logic                                  capture,
  input  logic                                  word_next,
  input  logic                                  bit_advance,
  output logic                                  ser_bit,
  output logic                                  last_bit,
  output logic                                  last_word
);

  localparam int WORD_W     = BYTE_W * BYTES_PER_WORD;
  localparam int BIT_W      = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int BYTE_IDX_W = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;
  localparam int IDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [BIT_W-1:0]      BIT_LAST  = BIT_W'(BYTE_W - 1);
  localparam logic [BYTE_IDX_W-1:0] BYTE_LAST = BYTE_IDX_W'(BYTES_PER_WORD - 1);
  localparam logic [IDX_W-1:0]      WORD_LAST = IDX_W'(NUM_WORDS - 1);

  logic [WORD_W-1:0] word_slice [NUM_WORDS];
  logic [WORD_W-1:0] store_q    [NUM_WORDS];
  logic [WORD_W-1:0] store_d    [NUM_WORDS];

  logic [WORD_W-1:0]     sh_q, sh_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [BYTE_IDX_W-1:0] byte_q, byte_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [IDX_W-1:0]      idx_inc;
  logic                  last_byte;

  // One slice per configured word; word 0 sits in the lowest bits.
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_slice
    assign word_slice[w] = words_in[w*WORD_W +: WORD_W];
  end

  assign idx_inc   = idx_q + 1'b1;
  assign last_byte = (byte_q == BYTE_LAST);
  assign last_bit  = last_byte && (bit_q == BIT_LAST);
  assign last_word = (idx_q == WORD_LAST);
  assign ser_bit   = sh_q[WORD_W-1];

  always_comb begin
    store_d = store_q;
    if (capture) store_d = word_slice;
  end

  always_comb begin
    sh_d   = sh_q;
    bit_d  = bit_q;
    byte_d = byte_q;
    idx_d  = idx_q;
    if (capture) begin
      // Storage is written on this edge, so load the first word straight from the bus.
      sh_d   = word_slice[0];
      bit_d  = '0;
      byte_d = '0;
      idx_d  = '0;
    end else if (word_next) begin
      idx_d = idx_inc;
      sh_d  = store_q[idx_inc];
    end else if (bit_advance) begin
      sh_d = {sh_q[WORD_W-2:0], 1'b0};
      if (bit_q == BIT_LAST) begin
        bit_d  = '0;
        byte_d = last_byte ? '0 : byte_q + 1'b1;
      end else begin
        bit_d = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) store_q[w] <= '0;
    end else begin
      store_q <= store_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bit_q  <= '0;
      byte_q <= '0;
      idx_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic last_bit,
  input  logic last_word,
  output logic capture,
  output logic word_next,
  output logic bit_advance,
  output logic timer_clear,
  output logic sclk_o,
  output logic data_en_o,
  output logic le_o,
  output logic done_o
);

  seq_state_e state_q, state_d;
  logic sclk_d, data_en_d, le_d, done_d;

  always_comb begin
    state_d     = state_q;
    capture     = 1'b0;
    word_next   = 1'b0;
    bit_advance = 1'b0;
    timer_clear = 1'b0;
    case (state_q)
      ST_LOAD: begin
        capture     = 1'b1;
        timer_clear = 1'b1;
        state_d     = ST_SETUP;
      end
      ST_SETUP: if (tick) state_d = ST_HIGH;
      ST_HIGH:  if (tick) state_d = ST_HOLD;
      ST_HOLD: begin
        if (tick) begin
          bit_advance = 1'b1;
          state_d     = last_bit ? ST_GAP : ST_SETUP;
        end
      end
      ST_GAP:   if (tick) state_d = ST_LATCH;
      ST_LATCH: begin
        if (tick) begin
          if (last_word) begin
            state_d = ST_DONE;
          end else begin
            word_next = 1'b1;
            state_d   = ST_SETUP;
          end
        end
      end
      ST_DONE: begin
        timer_clear = 1'b1;
        if (start) begin
          capture = 1'b1;
          state_d = ST_SETUP;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  // Outputs are registered from the next state so the pins never glitch.
  always_comb begin
    sclk_d    = (state_d == ST_HIGH);
    le_d      = (state_d == ST_LATCH);
    done_d    = (state_d == ST_DONE);
    data_en_d = (state_d == ST_SETUP) || (state_d == ST_HIGH) || (state_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOAD;
      sclk_o    <= 1'b0;
      data_en_o <= 1'b0;
      le_o      <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      state_q   <= state_d;
      sclk_o    <= sclk_d;
      data_en_o <= data_en_d;
      le_o      <= le_d;
      done_o    <= done_d;
    end
  end

endmodule

// File: rtl/synth_cfg_seq.sv
module synth_cfg_seq #(
  parameter int PHASE_CYC      = 4,
  parameter int BYTE_W         = 8,
  parameter int BYTES_PER_WORD = 3,
  parameter int NUM_WORDS      = 4
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       start,
  input  logic [NUM_WORDS*BYTE_W*BYTES_PER_WORD-1:0] cfg_words,
  output logic                                       ser_clk,
  output logic                                       ser_data,
  output logic                                       latch_en,
  output logic                                       done
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick, timer_clear;
  logic       capture, word_next, bit_advance;
  logic       ser_bit, last_bit, last_word;
  logic       data_en;

  // Reset asserts at once and is released two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cfg_phase_timer #(
    .PHASE_CYC(PHASE_CYC)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (timer_clear),
    .tick  (tick)
  );

  cfg_word_shifter #(
    .BYTE_W         (BYTE_W),
    .BYTES_PER_WORD (BYTES_PER_WORD),
    .NUM_WORDS      (NUM_WORDS)
  ) u_shifter (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .words_in    (cfg_words),
    .capture     (capture),
    .word_next   (word_next),
    .bit_advance (bit_advance),
    .ser_bit     (ser_bit),
    .last_bit    (last_bit),
    .last_word   (last_word)
  );

  cfg_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start       (start),
    .tick        (tick),
    .last_bit    (last_bit),
    .last_word   (last_word),
    .capture     (capture),
    .word_next   (word_next),
    .bit_advance (bit_advance),
    .timer_clear (timer_clear),
    .sclk_o      (ser_clk),
    .data_en_o   (data_en),
    .le_o        (latch_en),
    .done_o      (done)
  );

  assign ser_data = data_en & ser_bit;

endmodule

// File: rtl/synth_cfg_seq_chk.sv
module synth_cfg_seq_chk #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 24
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic sclk,
  input logic sdata,
  input logic le,
  input logic done
);

  localparam int SC_W = $clog2(WORD_W + 1);
  localparam int LC_W = $clog2(NUM_WORDS + 1);

  logic            sclk_p, le_p;
  logic [SC_W-1:0] sclk_cnt;
  logic [LC_W-1:0] le_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p   <= 1'b0;
      le_p     <= 1'b0;
      sclk_cnt <= '0;
      le_cnt   <= '0;
    end else begin
      sclk_p <= sclk;
      le_p   <= le;
      if (le && !le_p)          sclk_cnt <= '0;
      else if (sclk && !sclk_p) sclk_cnt <= sclk_cnt + 1'b1;
      if (done && start)        le_cnt <= '0;
      else if (le && !le_p)     le_cnt <= le_cnt + 1'b1;
    end
  end

  assert_word_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !le_p) |-> (le_cnt < LC_W'(NUM_WORDS)));

  assert_word_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (le && !le_p) |-> (sclk_cnt == SC_W'(WORD_W)));

  assert_setup_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(sdata));

  assert_clk_low_in_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    le |-> !sclk);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && !sdata && !le));

  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_rerun_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> !done);

endmodule

bind synth_cfg_seq synth_cfg_seq_chk #(
  .NUM_WORDS (NUM_WORDS),
  .WORD_W    (BYTE_W * BYTES_PER_WORD)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .start (start),
  .sclk  (ser_clk),
  .sdata (ser_data),
  .le    (latch_en),
  .done  (done)
);

// File: tb/synth_cfg_seq_tb.sv
`timescale 1ns/1ps
module synth_cfg_seq_tb;

  localparam int PH = 3;
  localparam int NW = 4;
  localparam int WW = 24;
  localparam int NV = 3;

  // Each entry: word 3 .. word 0, word 0 in the low bits and sent first.
  localparam logic [NW*WW-1:0] VEC [NV] = '{
    {24'h0000C8, 24'h008C51, 24'h9F8092, 24'h9F8093},
    {24'h555555, 24'hAAAAAA, 24'h000000, 24'hFFFFFF},
    {24'hC0FFEE, 24'h123456, 24'h7FFFFE, 24'h800001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [NW*WW-1:0] cfg_words;
  logic ser_clk, ser_data, latch_en, done;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  synth_cfg_seq #(.PHASE_CYC(PH)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_words (cfg_words),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .latch_en  (latch_en),
    .done      (done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Waveform monitor: rebuilds words and measures phase lengths.
  logic        ps, pd, pl;
  int          since_data, since_fall, hi_len, le_len, bitcnt, rx_cnt;
  logic [WW-1:0] shreg;
  logic [WW-1:0] rx_words [64];

  always @(negedge clk) begin
    if (!rst_n) begin
      ps = 0; pd = 0; pl = 0;
      since_data = PH; since_fall = PH; hi_len = 0; le_len = 0; bitcnt = 0;
      shreg = '0;
    end else begin
      since_data++; since_fall++; hi_len++; le_len++;
      if (ser_data !== pd) begin
        check(!ser_clk, "R4 data moved while clock high", int'(ser_clk), 0);
        check(since_fall >= PH, "R4 data hold after clock fall", since_fall, PH);
        since_data = 0;
      end
      if (ser_clk && !ps) begin
        check(since_data >= PH, "R4 data setup before clock rise", since_data, PH);
        check(since_fall >= PH, "R4 clock low time", since_fall, PH);
        shreg = {shreg[WW-2:0], ser_data};
        bitcnt++;
        hi_len = 0;
      end
      if (!ser_clk && ps) begin
        check(hi_len == PH, "R4 clock high width", hi_len, PH);
        since_fall = 0;
      end
      if (latch_en && !pl) begin
        check(bitcnt == WW, "R3 clock rises per word", bitcnt, WW);
        check(since_fall >= PH, "R5 clock to latch spacing", since_fall, PH);
        rx_words[rx_cnt % 64] = shreg;
        rx_cnt++;
        bitcnt = 0;
        le_len = 0;
      end
      if (!latch_en && pl) check(le_len == PH, "R5 latch width", le_len, PH);
      if (latch_en) check(!ser_clk, "R5 clock low during latch", int'(ser_clk), 0);
      ps = ser_clk; pd = ser_data; pl = latch_en;
    end
  end

  task automatic wait_done(input string tag);
    bit   seen = 0;
    logic prev_le = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        check(prev_le, "R6 done rises as last latch pulse ends", int'(prev_le), 1);
      end
      prev_le = latch_en;
    end
    check(seen, {"R6 done reached ", tag}, int'(seen), 1);
  endtask

  task automatic check_words(input int base, input logic [NW*WW-1:0] exp_set, input string tag);
    check(rx_cnt - base == NW, {"R2 word count ", tag}, rx_cnt - base, NW);
    for (int i = 0; i < NW; i++)
      check(rx_words[(base + i) % 64] == exp_set[i*WW +: WW],
            {"R2 R3 word order and bit order ", tag},
            int'(rx_words[(base + i) % 64]), int'(exp_set[i*WW +: WW]));
  endtask

  initial begin
    int base;
    rx_cnt = 0;
    rst_n = 1'b0;
    start = 1'b0;
    cfg_words = VEC[0];
    repeat (5) @(negedge clk);
    // R1: reset state
    check(!ser_clk && !ser_data && !latch_en && !done, "R1 outputs low in reset",
          {ser_clk, ser_data, latch_en, done}, 0);
    base = rx_cnt;
    rst_n = 1'b1;
    wait_done("first run");
    check_words(base, VEC[0], "after reset");

    // R7: idle stays quiet
    base = rx_cnt;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      check(done && !ser_clk && !ser_data && !latch_en, "R7 idle outputs",
            {done, ser_clk, ser_data, latch_en}, 4'b1000);
    end
    check(rx_cnt == base, "R7 no latch pulse while idle", rx_cnt - base, 0);

    // Table walk: each set is launched by start, disturbed mid-run.
    for (int k = 0; k < NV; k++) begin
      cfg_words = VEC[k];
      @(negedge clk);
      start = 1'b1;
      base = rx_cnt;
      @(negedge clk);
      start = 1'b0;
      check(!done, "R8 done drops after start", int'(done), 0);
      repeat (30) @(negedge clk);
      cfg_words = ~VEC[k];           // R9: must not reach the pins
      start = 1'b1;                  // R9: ignored while running
      @(negedge clk);
      start = 1'b0;
      wait_done("table run");
      check_words(base, VEC[k], "R8 R9 table run");
    end

    // R1: reset in mid-word, then a fresh run with new words.
    cfg_words = VEC[2];
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!ser_clk && !ser_data && !latch_en && !done, "R1 outputs low on mid-run reset",
          {ser_clk, ser_data, latch_en, done}, 0);
    cfg_words = VEC[1];
    repeat (3) @(negedge clk);
    base = rx_cnt;
    rst_n = 1'b1;
    wait_done("after mid-run reset");
    check_words(base, VEC[1], "R1 restart");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule